// File: doc/BRIEF.md
# Interrupt Status and Mask Pair

This block holds two registers of equal width at adjacent bus addresses. The first is an interrupt status register. Hardware sets its bits through a per-bit set input, and software clears them by writing ones. The second is a mask register that software reads and writes. A mask bit at one keeps the matching status bit from reaching the interrupt request line, but the status bit still records the event.

A single registered request line, `irq_o`, is high when any unmasked status bit is set. Bus access is a plain single-cycle write strobe with an address and write data. Read data is a combinational function of the address and the current register state.

Top module: `irq_pair`

## Requirements
- R1: After reset the status register reads zero, the mask register reads the parameter `MASK_RST`, and `irq_o` is low.
- R2: A one on bit n of `set_i` at a clock edge makes status bit n read one after that edge.
- R3: The status register is at address `BASE_ADDR`. A write there clears every status bit whose write-data bit is one and leaves every bit whose write-data bit is zero unchanged.
- R4: No write at any address sets a status bit. A status bit rises only when its `set_i` bit is high.
- R5: When a set and a write-one-to-clear hit the same status bit at the same edge, the bit reads one afterwards.
- R6: The mask register is at address `BASE_ADDR+1`. A write there loads all bits from the write data, and the value reads back at that address.
- R7: A status bit latches even while its mask bit is one.
- R8: `irq_o` equals, one clock after any edge, the OR over all bits of (status AND NOT mask) as they stood before that edge. A mask bit of one suppresses its source and a mask bit of zero enables it.
- R9: A write to any address other than the pair leaves both registers unchanged. A read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | DW | Hardware set request, one bit per source |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | AW | Bus address for reads and writes |
| wdata_i | input | DW | Bus write data |
| rdata_o | output | DW | Read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bound checker looks at every cycle for five things:
- a status bit that rises without its set input;
- a set that fails to latch;
- a written one that fails to clear where no set competes;
- a mask that changes without a write to its address, or fails to load;
- a request line that does not track the masked status one cycle later.

The bench's directed scenarios are needed for the reset values and the read-back decoding at both addresses and at foreign addresses. The same holds for the exact outcome when a set and a clear collide, and for sources latching while masked. A long stretch of pseudo-random set, write and address traffic is then compared cycle by cycle against a behavioural model.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pair_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);
  localparam logic [AW-1:0] MaskAddr = AW'(BASE_ADDR + 1'b1);

  always_comb begin
    if (addr_i == BASE_ADDR)     sel_o = SEL_STATUS;
    else if (addr_i == MaskAddr) sel_o = SEL_MASK;
    else                         sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] status_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  bit_q <= 1'b0;
      else if (set_i[b])            bit_q <= 1'b1;  // set beats clear
      else if (clr_en_i && clr_i[b]) bit_q <= 1'b0;
    end
    assign status_o[b] = bit_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] MASK_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= MASK_RST;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  output logic          irq_o
);
  logic [DW-1:0] pend;
  assign pend = status_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend;
  end
endmodule

// File: rtl/irq_pair.sv
module irq_pair
  import irq_pair_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter logic [AW-1:0] BASE_ADDR = 4'h4,
  parameter logic [DW-1:0] MASK_RST = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  reg_sel_e      sel;
  logic [DW-1:0] status_q;
  logic [DW-1:0] mask_q;

  irq_addr_dec #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  irq_status_reg #(.DW(DW)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_i),
    .clr_en_i (wr_en_i && sel == SEL_STATUS),
    .clr_i    (wdata_i),
    .status_o (status_q)
  );

  irq_mask_reg #(.DW(DW), .MASK_RST(MASK_RST)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && sel == SEL_MASK),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  irq_req_gen #(.DW(DW)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_q;
      SEL_MASK:   rdata_o = mask_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_pair_chk.sv
module irq_pair_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter logic [AW-1:0] BASE_ADDR = 4'h4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] set_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] mask_q,
  input logic          irq_o
);
  logic wr_stat, wr_mask;
  assign wr_stat = wr_en_i && (addr_i == BASE_ADDR);
  assign wr_mask = wr_en_i && (addr_i == AW'(BASE_ADDR + 1'b1));

  AST_SET_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(set_i)) == $past(set_i)));  // R2
  AST_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));  // R4
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((status_q & $past(wdata_i) & ~$past(set_i)) == '0));  // R3
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_q == $past(wdata_i)));  // R6
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));  // R9
  AST_IRQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_q & ~mask_q))));  // R8
endmodule

bind irq_pair irq_pair_chk #(.DW(DW), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .set_i    (set_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .status_q (status_q),
  .mask_q   (mask_q),
  .irq_o    (irq_o)
);

// File: tb/irq_pair_tb.sv
`timescale 1ns/1ps
module irq_pair_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] BASE = 4'h4;
  localparam logic [AW-1:0] MADR = 4'h5;
  localparam logic [DW-1:0] MRST = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] set_i = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_status;
  logic [DW-1:0] m_mask;
  logic m_irq;

  always #2.5 clk = ~clk;

  irq_pair #(.DW(DW), .AW(AW), .BASE_ADDR(BASE), .MASK_RST(MRST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_i), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    if (a == BASE) return m_status;
    if (a == MADR) return m_mask;
    return '0;
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic [DW-1:0] s, input logic we, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string req);
    logic nirq;
    logic [DW-1:0] e;
    set_i = s; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    nirq = |(m_status & ~m_mask);
    if (we && a == BASE) m_status = m_status & ~d;
    if (we && a == MADR) m_mask = d;
    m_status = m_status | s;
    m_irq = nirq;
    @(negedge clk);
    e = exp_read(a);
    check(rdata == e, {req, " rdata"}, int'(rdata), int'(e));
    check(irq == m_irq, {req, " irq"}, int'(irq), int'(m_irq));
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc('0, 1'b0, a, '0, req);
  endtask

  initial begin
    logic [15:0] lfsr;
    m_status = '0; m_mask = MRST; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    addr = BASE; #1;
    check(rdata == 8'h00, "R1 status reset", int'(rdata), 0);
    check(irq == 1'b0, "R1 irq reset", int'(irq), 0);
    addr = MADR; #1;
    check(rdata == MRST, "R1 mask reset", int'(rdata), int'(MRST));
    @(negedge clk);
    // R6 mask write and readback
    cyc('0, 1'b1, MADR, 8'h00, "R6");
    rd(MADR, "R6");
    check(rdata == 8'h00, "R6 mask readback", int'(rdata), 0);
    // R2 set, R8 irq follows
    cyc(8'h01, 1'b0, BASE, '0, "R2");
    check(rdata == 8'h01, "R2 status bit0", int'(rdata), 1);
    rd(BASE, "R8");
    check(irq == 1'b1, "R8 irq up", int'(irq), 1);
    // R3 write zero keeps, write one clears
    cyc('0, 1'b1, BASE, 8'h00, "R3");
    check(rdata == 8'h01, "R3 zero no effect", int'(rdata), 1);
    cyc('0, 1'b1, BASE, 8'h01, "R3");
    check(rdata == 8'h00, "R3 one clears", int'(rdata), 0);
    rd(BASE, "R8");
    check(irq == 1'b0, "R8 irq down", int'(irq), 0);
    // R4 software cannot set
    cyc('0, 1'b1, BASE, 8'hFF, "R4");
    check(rdata == 8'h00, "R4 no sw set", int'(rdata), 0);
    // R5 set beats clear
    cyc(8'h08, 1'b1, BASE, 8'h08, "R5");
    check(rdata == 8'h08, "R5 set wins", int'(rdata), 8'h08);
    cyc('0, 1'b1, BASE, 8'hFF, "R3");
    // R7 masked source still latches, irq suppressed
    cyc('0, 1'b1, MADR, 8'h04, "R7");
    cyc(8'h04, 1'b0, BASE, '0, "R7");
    check(rdata == 8'h04, "R7 latched while masked", int'(rdata), 8'h04);
    rd(BASE, "R8");
    check(irq == 1'b0, "R8 masked no irq", int'(irq), 0);
    cyc('0, 1'b1, MADR, 8'h00, "R8");
    rd(BASE, "R8");
    check(irq == 1'b1, "R8 unmask raises irq", int'(irq), 1);
    // R9 foreign address writes ignored, read zero
    cyc('0, 1'b1, 4'h0, 8'hFF, "R9");
    check(rdata == 8'h00, "R9 foreign read", int'(rdata), 0);
    cyc('0, 1'b1, 4'hF, 8'hAA, "R9");
    rd(MADR, "R9");
    check(rdata == 8'h00, "R9 mask untouched", int'(rdata), 0);
    rd(BASE, "R9");
    check(rdata == 8'h04, "R9 status untouched", int'(rdata), 8'h04);
    // R8 pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[2] ? (lfsr[3] ? BASE : MADR) : lfsr[7:4];
      cyc((lfsr[9:8] == 2'b00) ? lfsr[15:8] : 8'h00, lfsr[0], a,
          lfsr[15:8] ^ lfsr[7:0], "R8 random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule